// File: doc/BRIEF.md
# Two-stage translation entry merger and hit permission checker

This block sits beside a two-stage IOMMU translation cache. On its merge path it takes a first-stage cached translation, a second-stage cached translation and the input virtual address. It produces one combined entry that the cache can store and look up with a single probe. The combined entry keeps the first-stage permission as its primary permission and the second-stage permission in a separate parent field. It keeps both because storing only the AND of the two would hide which stage refused an access.

On its check path the block takes the entry that a cache lookup hit, together with the read and write flags of the request. It decides, purely combinationally, whether the access may proceed. When it may not, it raises a permission fault and names the stage that lacks the right. The merge path is one registered stage with a valid/ready handshake on each side. When the nest enable is low, it turns a single-stage entry into the same stored form, with the parent permission copying the primary one.

Top module: `nest_combiner`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted input appears on the outputs with `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, every combined output holds its value.
- R3: With nesting on, the combined mask, granule and level all come from the second-stage entry when its mask is numerically smaller than the first-stage mask. Otherwise, including on equal masks, they come from the first-stage entry.
- R4: The combined input address is the input virtual address with the bits of the selected mask cleared.
- R5: With nesting on, the combined output address is `(s2_oaddr & ~s2_mask) | (s1_oaddr & s2_mask)`. That is, the second-stage base plus the intermediate-address offset within the second-stage page.
- R6: With nesting on, `cmb_perm` is the first-stage permission and `cmb_pperm` is the second-stage permission. Permission encoding: bit 0 = read, bit 1 = write.
- R7: With nesting off, mask, granule, level, output address and primary permission all come from the first-stage entry. `cmb_pperm` equals `cmb_perm`, and the input address is masked with the first-stage mask.
- R8: On a hit with `req_wr` high, the access is allowed only if bit 1 is set in both `hit_perm` and `hit_pperm`. Otherwise `chk_fault`=1, `chk_ok`=0 and `chk_oaddr`=0.
- R9: On a hit with `req_rd` high, the same rule applies to bit 0.
- R10: On a fault, `chk_stage` is 0 (stage 1) when `hit_perm` lacks a requested bit, and 1 (stage 2) otherwise. Without a fault it reads 0.
- R11: With `hit_valid` low, `chk_ok` and `chk_fault` are both 0 and `chk_oaddr` is 0.
- R12: A hit with no request bit set is allowed whatever the permissions, and `chk_oaddr` equals `hit_oaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Merge request valid |
| in_ready | output | 1 | Merge request accepted this cycle |
| nest_en | input | 1 | 1: merge both stages; 0: single-stage entry |
| iova | input | AW | Input virtual address |
| s1_mask | input | AW | First-stage address mask |
| s1_gran | input | GW | First-stage granule code |
| s1_level | input | LVW | First-stage table level |
| s1_oaddr | input | AW | First-stage output (intermediate) address |
| s1_perm | input | 2 | First-stage permission |
| s2_mask | input | AW | Second-stage address mask |
| s2_gran | input | GW | Second-stage granule code |
| s2_level | input | LVW | Second-stage table level |
| s2_oaddr | input | AW | Second-stage output address |
| s2_perm | input | 2 | Second-stage permission |
| out_valid | output | 1 | Combined entry valid |
| out_ready | input | 1 | Consumer takes combined entry |
| cmb_mask | output | AW | Combined mask |
| cmb_gran | output | GW | Combined granule |
| cmb_level | output | LVW | Combined level |
| cmb_iova | output | AW | Combined cached input address |
| cmb_oaddr | output | AW | Combined output address |
| cmb_perm | output | 2 | Primary permission |
| cmb_pperm | output | 2 | Parent permission |
| hit_valid | input | 1 | Lookup hit present |
| hit_oaddr | input | AW | Output address of hit entry |
| hit_perm | input | 2 | Primary permission of hit entry |
| hit_pperm | input | 2 | Parent permission of hit entry |
| req_rd | input | 1 | Access requests read |
| req_wr | input | 1 | Access requests write |
| chk_ok | output | 1 | Access allowed; translation valid |
| chk_fault | output | 1 | Permission fault |
| chk_stage | output | 1 | Faulting stage: 0 = stage 1, 1 = stage 2 |
| chk_oaddr | output | AW | Translated address, 0 unless allowed |

## Verification
A merged entry is due exactly one clock after the edge that accepts it. The driver pushes each expected entry into a queue when it presents the request. The monitor pops and compares only on a falling edge at which `out_valid` and `out_ready` are both high, so every result is read half a period after the edge that produced it. During a stall the bench reads the outputs on two successive falling edges and requires them to match. The lookup check has no latency: its inputs change on a falling edge and its outputs are read one nanosecond later, well before the next rising edge.

// File: rtl/nest_pkg.sv
package nest_pkg;
   localparam int PERM_W = 2;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   typedef enum logic {
      STG_FIRST  = 1'b0,
      STG_SECOND = 1'b1
   } stage_e;
endpackage

// File: rtl/nest_pick.sv
module nest_pick #(
   parameter int AW  = 48,
   parameter int GW  = 2,
   parameter int LVW = 2
) (
   input  logic           nest_en,
   input  logic [AW-1:0]  iova,
   input  logic [AW-1:0]  s1_mask,
   input  logic [GW-1:0]  s1_gran,
   input  logic [LVW-1:0] s1_level,
   input  logic [AW-1:0]  s2_mask,
   input  logic [GW-1:0]  s2_gran,
   input  logic [LVW-1:0] s2_level,
   output logic [AW-1:0]  sel_mask,
   output logic [GW-1:0]  sel_gran,
   output logic [LVW-1:0] sel_level,
   output logic [AW-1:0]  sel_iova
);
   logic take_second;

   // strict compare keeps the first stage on equal masks
   assign take_second = nest_en && (s2_mask < s1_mask);

   always_comb begin
      sel_mask  = take_second ? s2_mask  : s1_mask;
      sel_gran  = take_second ? s2_gran  : s1_gran;
      sel_level = take_second ? s2_level : s1_level;
      sel_iova  = iova & ~sel_mask;
   end
endmodule

// File: rtl/nest_oaddr.sv
module nest_oaddr #(
   parameter int AW = 48
) (
   input  logic          nest_en,
   input  logic [AW-1:0] s1_oaddr,
   input  logic [AW-1:0] s2_oaddr,
   input  logic [AW-1:0] s2_mask,
   output logic [AW-1:0] oaddr
);
   logic [AW-1:0] composed;

   // second-stage page base plus the intermediate offset inside that page
   assign composed = (s2_oaddr & ~s2_mask) | (s1_oaddr & s2_mask);
   assign oaddr    = nest_en ? composed : s1_oaddr;
endmodule

// File: rtl/nest_permchk.sv
module nest_permchk
   import nest_pkg::*;
#(
   parameter int AW = 48
) (
   input  logic              hit_valid,
   input  logic [AW-1:0]     hit_oaddr,
   input  logic [PERM_W-1:0] hit_perm,
   input  logic [PERM_W-1:0] hit_pperm,
   input  logic              req_rd,
   input  logic              req_wr,
   output logic              chk_ok,
   output logic              chk_fault,
   output logic              chk_stage,
   output logic [AW-1:0]     chk_oaddr
);
   logic [PERM_W-1:0] want;
   logic [PERM_W-1:0] lack_first;
   logic [PERM_W-1:0] lack_any;

   always_comb begin
      want          = '0;
      want[PERM_RD] = req_rd;
      want[PERM_WR] = req_wr;
   end

   for (genvar b = 0; b < PERM_W; b++) begin : g_bit
      assign lack_first[b] = want[b] & ~hit_perm[b];
      assign lack_any[b]   = want[b] & ~(hit_perm[b] & hit_pperm[b]);
   end

   always_comb begin
      chk_fault = hit_valid & (|lack_any);
      chk_ok    = hit_valid & ~(|lack_any);
      chk_stage = STG_FIRST;
      if (chk_fault && !(|lack_first))
         chk_stage = STG_SECOND;
      chk_oaddr = chk_ok ? hit_oaddr : '0;
   end
endmodule

// File: rtl/nest_combiner.sv
module nest_combiner
   import nest_pkg::*;
#(
   parameter int AW  = 48,
   parameter int GW  = 2,
   parameter int LVW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              nest_en,
   input  logic [AW-1:0]     iova,
   input  logic [AW-1:0]     s1_mask,
   input  logic [GW-1:0]     s1_gran,
   input  logic [LVW-1:0]    s1_level,
   input  logic [AW-1:0]     s1_oaddr,
   input  logic [PERM_W-1:0] s1_perm,
   input  logic [AW-1:0]     s2_mask,
   input  logic [GW-1:0]     s2_gran,
   input  logic [LVW-1:0]    s2_level,
   input  logic [AW-1:0]     s2_oaddr,
   input  logic [PERM_W-1:0] s2_perm,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     cmb_mask,
   output logic [GW-1:0]     cmb_gran,
   output logic [LVW-1:0]    cmb_level,
   output logic [AW-1:0]     cmb_iova,
   output logic [AW-1:0]     cmb_oaddr,
   output logic [PERM_W-1:0] cmb_perm,
   output logic [PERM_W-1:0] cmb_pperm,
   input  logic              hit_valid,
   input  logic [AW-1:0]     hit_oaddr,
   input  logic [PERM_W-1:0] hit_perm,
   input  logic [PERM_W-1:0] hit_pperm,
   input  logic              req_rd,
   input  logic              req_wr,
   output logic              chk_ok,
   output logic              chk_fault,
   output logic              chk_stage,
   output logic [AW-1:0]     chk_oaddr
);
   if (AW < 12 || AW > 64) begin : g_bad_aw
      $error("nest_combiner: AW must lie in 12..64");
   end
   if (GW < 1 || LVW < 1) begin : g_bad_fields
      $error("nest_combiner: GW and LVW must be at least 1");
   end

   logic [AW-1:0]     n_mask;
   logic [GW-1:0]     n_gran;
   logic [LVW-1:0]    n_level;
   logic [AW-1:0]     n_iova;
   logic [AW-1:0]     n_oaddr;
   logic [PERM_W-1:0] n_pperm;
   logic              take;

   nest_pick #(.AW(AW), .GW(GW), .LVW(LVW)) pick_i (
      .nest_en   (nest_en),
      .iova      (iova),
      .s1_mask   (s1_mask),
      .s1_gran   (s1_gran),
      .s1_level  (s1_level),
      .s2_mask   (s2_mask),
      .s2_gran   (s2_gran),
      .s2_level  (s2_level),
      .sel_mask  (n_mask),
      .sel_gran  (n_gran),
      .sel_level (n_level),
      .sel_iova  (n_iova)
   );

   nest_oaddr #(.AW(AW)) oaddr_i (
      .nest_en  (nest_en),
      .s1_oaddr (s1_oaddr),
      .s2_oaddr (s2_oaddr),
      .s2_mask  (s2_mask),
      .oaddr    (n_oaddr)
   );

   // single-stage entries mirror the primary permission into the parent field
   assign n_pperm  = nest_en ? s2_perm : s1_perm;
   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmb_mask  <= '0;
         cmb_gran  <= '0;
         cmb_level <= '0;
         cmb_iova  <= '0;
         cmb_oaddr <= '0;
         cmb_perm  <= '0;
         cmb_pperm <= '0;
      end else if (take) begin
         cmb_mask  <= n_mask;
         cmb_gran  <= n_gran;
         cmb_level <= n_level;
         cmb_iova  <= n_iova;
         cmb_oaddr <= n_oaddr;
         cmb_perm  <= s1_perm;
         cmb_pperm <= n_pperm;
      end
   end

   nest_permchk #(.AW(AW)) chk_i (
      .hit_valid (hit_valid),
      .hit_oaddr (hit_oaddr),
      .hit_perm  (hit_perm),
      .hit_pperm (hit_pperm),
      .req_rd    (req_rd),
      .req_wr    (req_wr),
      .chk_ok    (chk_ok),
      .chk_fault (chk_fault),
      .chk_stage (chk_stage),
      .chk_oaddr (chk_oaddr)
   );
endmodule

// File: rtl/nest_combiner_chk.sv
module nest_combiner_chk #(
   parameter int AW  = 48,
   parameter int GW  = 2,
   parameter int LVW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic           nest_en,
   input logic [AW-1:0]  s1_mask,
   input logic [GW-1:0]  s1_gran,
   input logic [AW-1:0]  s2_mask,
   input logic [GW-1:0]  s2_gran,
   input logic           out_valid,
   input logic           out_ready,
   input logic [AW-1:0]  cmb_mask,
   input logic [GW-1:0]  cmb_gran,
   input logic [AW-1:0]  cmb_iova,
   input logic [AW-1:0]  cmb_oaddr,
   input logic [1:0]     cmb_perm,
   input logic [1:0]     cmb_pperm,
   input logic           hit_valid,
   input logic [1:0]     hit_perm,
   input logic [1:0]     hit_pperm,
   input logic           req_rd,
   input logic           req_wr,
   input logic           chk_ok,
   input logic           chk_fault,
   input logic           chk_stage,
   input logic [AW-1:0]  chk_oaddr
);
   logic lack1;
   assign lack1 = (req_wr && !hit_perm[1]) || (req_rd && !hit_perm[0]);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(cmb_oaddr)
         && $stable(cmb_iova) && $stable(cmb_mask) && $stable(cmb_pperm));

   assert_pick_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && nest_en && (s2_mask < s1_mask)
      |=> cmb_mask == $past(s2_mask) && cmb_gran == $past(s2_gran));

   assert_pick_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !(s2_mask < s1_mask)
      |=> cmb_mask == $past(s1_mask) && cmb_gran == $past(s1_gran));

   assert_iova_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cmb_iova & cmb_mask) == '0);

   assert_single_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !nest_en |=> cmb_pperm == cmb_perm);

   assert_wr_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid && req_wr && !(hit_perm[1] && hit_pperm[1])
      |-> chk_fault && !chk_ok && chk_oaddr == '0);

   assert_rd_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid && req_rd && !(hit_perm[0] && hit_pperm[0])
      |-> chk_fault && !chk_ok && chk_oaddr == '0);

   assert_stage_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_fault && lack1 |-> chk_stage == 1'b0);

   assert_stage_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_fault && !lack1 |-> chk_stage == 1'b1);

   assert_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> !chk_ok && !chk_fault);

   assert_no_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid && !req_rd && !req_wr |-> chk_ok);
endmodule

bind nest_combiner nest_combiner_chk #(.AW(AW), .GW(GW), .LVW(LVW)) assert_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .nest_en   (nest_en),
   .s1_mask   (s1_mask),
   .s1_gran   (s1_gran),
   .s2_mask   (s2_mask),
   .s2_gran   (s2_gran),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .cmb_mask  (cmb_mask),
   .cmb_gran  (cmb_gran),
   .cmb_iova  (cmb_iova),
   .cmb_oaddr (cmb_oaddr),
   .cmb_perm  (cmb_perm),
   .cmb_pperm (cmb_pperm),
   .hit_valid (hit_valid),
   .hit_perm  (hit_perm),
   .hit_pperm (hit_pperm),
   .req_rd    (req_rd),
   .req_wr    (req_wr),
   .chk_ok    (chk_ok),
   .chk_fault (chk_fault),
   .chk_stage (chk_stage),
   .chk_oaddr (chk_oaddr)
);

// File: tb/nest_combiner_tb_top.sv
module nest_combiner_tb_top;
   localparam int AW  = 48;
   localparam int GW  = 2;
   localparam int LVW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic           nest_en = 1'b0;
   logic [AW-1:0]  iova = '0;
   logic [AW-1:0]  s1_mask = '0, s1_oaddr = '0, s2_mask = '0, s2_oaddr = '0;
   logic [GW-1:0]  s1_gran = '0, s2_gran = '0;
   logic [LVW-1:0] s1_level = '0, s2_level = '0;
   logic [1:0]     s1_perm = '0, s2_perm = '0;
   logic           out_valid;
   logic           out_ready = 1'b1;
   logic [AW-1:0]  cmb_mask, cmb_iova, cmb_oaddr;
   logic [GW-1:0]  cmb_gran;
   logic [LVW-1:0] cmb_level;
   logic [1:0]     cmb_perm, cmb_pperm;
   logic           hit_valid = 1'b0;
   logic [AW-1:0]  hit_oaddr = '0;
   logic [1:0]     hit_perm = '0, hit_pperm = '0;
   logic           req_rd = 1'b0, req_wr = 1'b0;
   logic           chk_ok, chk_fault, chk_stage;
   logic [AW-1:0]  chk_oaddr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [AW-1:0]  mask;
      logic [GW-1:0]  gran;
      logic [LVW-1:0] level;
      logic [AW-1:0]  iova;
      logic [AW-1:0]  oaddr;
      logic [1:0]     perm;
      logic [1:0]     pperm;
      string          tag;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   nest_combiner #(.AW(AW), .GW(GW), .LVW(LVW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .nest_en(nest_en), .iova(iova),
      .s1_mask(s1_mask), .s1_gran(s1_gran), .s1_level(s1_level),
      .s1_oaddr(s1_oaddr), .s1_perm(s1_perm),
      .s2_mask(s2_mask), .s2_gran(s2_gran), .s2_level(s2_level),
      .s2_oaddr(s2_oaddr), .s2_perm(s2_perm),
      .out_valid(out_valid), .out_ready(out_ready),
      .cmb_mask(cmb_mask), .cmb_gran(cmb_gran), .cmb_level(cmb_level),
      .cmb_iova(cmb_iova), .cmb_oaddr(cmb_oaddr), .cmb_perm(cmb_perm),
      .cmb_pperm(cmb_pperm),
      .hit_valid(hit_valid), .hit_oaddr(hit_oaddr), .hit_perm(hit_perm),
      .hit_pperm(hit_pperm), .req_rd(req_rd), .req_wr(req_wr),
      .chk_ok(chk_ok), .chk_fault(chk_fault), .chk_stage(chk_stage),
      .chk_oaddr(chk_oaddr)
   );

   task automatic check(input bit ok, input string what);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", what);
      end
   endtask

   // driver: compute the expected entry from the requirements, queue it, present it
   task automatic send(input bit nst, input logic [AW-1:0] va,
                       input logic [AW-1:0] m1, input logic [GW-1:0] g1,
                       input logic [LVW-1:0] l1, input logic [AW-1:0] o1,
                       input logic [1:0] p1,
                       input logic [AW-1:0] m2, input logic [GW-1:0] g2,
                       input logic [LVW-1:0] l2, input logic [AW-1:0] o2,
                       input logic [1:0] p2, input string tag);
      exp_t e;
      bit second;
      second  = nst && (m2 < m1);
      e.mask  = second ? m2 : m1;
      e.gran  = second ? g2 : g1;
      e.level = second ? l2 : l1;
      e.iova  = va & ~e.mask;
      e.oaddr = nst ? ((o2 & ~m2) | (o1 & m2)) : o1;
      e.perm  = p1;
      e.pperm = nst ? p2 : p1;
      e.tag   = tag;
      sb.push_back(e);
      nest_en = nst; iova = va;
      s1_mask = m1; s1_gran = g1; s1_level = l1; s1_oaddr = o1; s1_perm = p1;
      s2_mask = m2; s2_gran = g2; s2_level = l2; s2_oaddr = o2; s2_perm = p2;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: one result per falling edge with valid and ready both high
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected output beat");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(cmb_mask == e.mask && cmb_gran == e.gran && cmb_level == e.level
                  && cmb_iova == e.iova && cmb_oaddr == e.oaddr
                  && cmb_perm == e.perm && cmb_pperm == e.pperm,
                  $sformatf("%s: got mask=%h gran=%0d lvl=%0d iova=%h oa=%h p=%b pp=%b exp mask=%h gran=%0d lvl=%0d iova=%h oa=%h p=%b pp=%b",
                            e.tag, cmb_mask, cmb_gran, cmb_level, cmb_iova, cmb_oaddr,
                            cmb_perm, cmb_pperm, e.mask, e.gran, e.level, e.iova,
                            e.oaddr, e.perm, e.pperm));
         end
      end
   end

   task automatic lookup(input bit hv, input logic [AW-1:0] oa,
                         input logic [1:0] p, input logic [1:0] pp,
                         input bit rd, input bit wr,
                         input bit x_ok, input bit x_fault, input bit x_stage,
                         input string tag);
      logic [AW-1:0] x_oa;
      @(negedge clk);
      hit_valid = hv; hit_oaddr = oa; hit_perm = p; hit_pperm = pp;
      req_rd = rd; req_wr = wr;
      #1;
      x_oa = x_ok ? oa : '0;
      check(chk_ok == x_ok && chk_fault == x_fault && chk_stage == x_stage
            && chk_oaddr == x_oa,
            $sformatf("%s: got ok=%b fault=%b stage=%b oa=%h exp ok=%b fault=%b stage=%b oa=%h",
                      tag, chk_ok, chk_fault, chk_stage, chk_oaddr,
                      x_ok, x_fault, x_stage, x_oa));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] h_mask, h_oaddr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1,
            $sformatf("R1 reset: got out_valid=%b in_ready=%b exp 0 1", out_valid, in_ready));

      // back-to-back merges with out_ready held high
      send(1'b1, 48'h1234_5678_9ABC, 48'hFFF, 2'd0, 2'd3, 48'h0000_4000_7000, 2'b11,
           48'h1F_FFFF, 2'd0, 2'd2, 48'h0008_8000_0000, 2'b01, "R3 R5 R6 first mask smaller");
      send(1'b1, 48'hABCD_EF01_2345, 48'h1F_FFFF, 2'd0, 2'd2, 48'h0000_0012_3456, 2'b01,
           48'hFFF, 2'd1, 2'd3, 48'h0000_7777_7000, 2'b11, "R3 R4 R5 second mask smaller");
      send(1'b1, 48'h0000_0000_5FFF, 48'hFFF, 2'd1, 2'd3, 48'h0000_0000_A000, 2'b10,
           48'hFFF, 2'd2, 2'd1, 48'h0000_0030_0000, 2'b01, "R3 equal masks keep first");
      send(1'b1, 48'hFFFF_FFFF_FFFF, 48'h3FFF_FFFF, 2'd2, 2'd1, 48'h0000_4123_4567, 2'b11,
           48'h1F_FFFF, 2'd2, 2'd2, 48'h0000_8000_0000, 2'b10, "R4 R5 R6 large pages");
      send(1'b0, 48'h0000_1234_5678, 48'hFFFF, 2'd3, 2'd3, 48'h0000_AAAA_0000, 2'b10,
           48'hFF, 2'd1, 2'd1, 48'h0000_5555_0000, 2'b01, "R7 single stage");
      send(1'b0, 48'h0000_0000_0FFF, 48'h1F_FFFF, 2'd0, 2'd2, 48'h0000_0060_0000, 2'b01,
           48'h0, 2'd0, 2'd0, 48'h0, 2'b11, "R7 single stage smaller second ignored");
      repeat (2) @(negedge clk);
      check(sb.size() == 0 && out_valid == 1'b0,
            $sformatf("R2 drain: got pending=%0d out_valid=%b exp 0 0", sb.size(), out_valid));

      // stall: output must hold while out_ready is low
      out_ready = 1'b0;
      send(1'b1, 48'h0000_0123_4567, 48'hFFFF, 2'd1, 2'd3, 48'h0000_0009_0000, 2'b11,
           48'hFFF, 2'd0, 2'd3, 48'h0000_00C0_0000, 2'b11, "R2 stalled entry");
      h_mask = cmb_mask; h_oaddr = cmb_oaddr;
      check(out_valid == 1'b1 && in_ready == 1'b0,
            $sformatf("R2 stall flags: got out_valid=%b in_ready=%b exp 1 0", out_valid, in_ready));
      @(negedge clk);
      check(cmb_mask == h_mask && cmb_oaddr == h_oaddr && out_valid == 1'b1,
            $sformatf("R2 hold: got mask=%h oa=%h exp mask=%h oa=%h", cmb_mask, cmb_oaddr,
                      h_mask, h_oaddr));
      @(posedge clk);
      #1 out_ready = 1'b1;
      repeat (2) @(negedge clk);
      check(sb.size() == 0,
            $sformatf("R2 stalled entry delivered: got pending=%0d exp 0", sb.size()));

      // lookup checks: perm bit0 = read, bit1 = write
      lookup(1'b1, 48'h0000_1234_5000, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 write allowed");
      lookup(1'b1, 48'h0000_1234_5000, 2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 R10 write lacks stage 1");
      lookup(1'b1, 48'h0000_1234_5000, 2'b11, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 R10 write lacks stage 2");
      lookup(1'b1, 48'h0000_1234_5000, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10 both lack, stage 1 named");
      lookup(1'b1, 48'h0000_0ABC_D000, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 read allowed");
      lookup(1'b1, 48'h0000_0ABC_D000, 2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 R10 read lacks stage 1");
      lookup(1'b1, 48'h0000_0ABC_D000, 2'b11, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9 R10 read lacks stage 2");
      lookup(1'b1, 48'h0000_0ABC_D000, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8 R9 read ok write lacks stage 1");
      lookup(1'b1, 48'h0000_0ABC_D000, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R8 R9 write ok read lacks stage 2");
      lookup(1'b0, 48'h0000_0ABC_D000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 no hit");
      lookup(1'b0, 48'h0000_0ABC_D000, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 no hit full perms");
      lookup(1'b1, 48'h0000_0FED_C000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R12 no request bits");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule